// File: doc/BRIEF.md
# GPU Command Packet Framer

The framer sits between a 32-bit command word stream and the drawing and transfer engines of a graphics pipeline. Words come in on a valid/ready port. The top byte of the first word of each packet is its opcode. From the opcode the framer decides how many words belong to the packet, collects them, and presents the whole packet on one output strobe. That strobe carries the opcode, the word count and every word of the packet side by side.

Most opcodes have a fixed length, computed from the opcode bits. Line-strip opcodes have no fixed length. They end on the first word, at an allowed position, that matches a terminator pattern. Image-transfer opcodes are not sent to the drawing output. Their position and size words go to a separate transfer port, together with a read/write flag.

Settings opcodes store their full word in one of eight environment registers. These registers drive a 13-bit status word, which is reloaded at the end of every batch of input words. A flush input drops a half-built packet at any time.

Top module: `gpf_framer`

## Requirements
- R1: The packet length is 1 plus an extra-word count that depends on the opcode (bits 31..24 of the first word). The counts are:
  - opcode 0x02: 2
  - 0x20–0x23: 3, 0x24–0x27: 6, 0x28–0x2B: 4, 0x2C–0x2F: 8
  - 0x30–0x33: 5, 0x34–0x37: 8, 0x38–0x3B: 7, 0x3C–0x3F: 11
  - 0x00 and 0xE0–0xFF: 0

  Each completed packet appears once, in arrival order, with pkt_opcode, pkt_count and its words in slots 0..pkt_count-1 of pkt_words (slot k at bits 32k+31..32k).
- R2: For opcodes 0x48–0x4F, the packet ends at the first word with index 3 or above that satisfies (word & 0xF000F000) == 0x50005000. That word is the last word of the packet. A matching word at index 1 or 2 does not end the packet.
- R3: For opcodes 0x58–0x5F, the terminator test is made only at word indices 4, 6, 8 and so on. A matching word at an odd index does not end the packet. The terminator is included in the packet.
- R4: A line-strip packet that has collected MAX_WORDS words without a terminator is emitted with pkt_count = MAX_WORDS. pkt_count is always between 1 and MAX_WORDS.
- R5: Opcodes 0xA0–0xDF take exactly 3 words and never appear on the packet output. They are presented once on the transfer port:
  - xfer_pos is word 1 and xfer_size is word 2.
  - xfer_read is 1 for 0xC0–0xDF and 0 for 0xA0–0xBF.
- R6: A first word with opcode 0xE0–0xE7 writes its full 32 bits into environment register (opcode & 7), which is slot i of env_regs. Other opcodes, such as 0xE8, change no environment register.
- R7: After reset, environment register i holds (0xE0 + i) << 24, status is 0, in_ready is 1 and neither output is valid.
- R8: Two clock edges after a word accepted with in_last = 1, status holds:
  - bits 10..0: bits 10..0 of environment register 1
  - bits 12..11: bits 1..0 of environment register 6
- R9: An incomplete packet is held without output for any number of idle cycles. It completes when its remaining words arrive.
- R10: A cycle with cmd_flush = 1 discards the partial packet and any pending output. The next accepted word is treated as a new first word.
- R11: in_ready is 0 while a packet or transfer is waiting. A waiting packet keeps its opcode and count until pkt_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_flush | input | 1 | Discard partial packet and pending output |
| in_valid | input | 1 | Command word valid |
| in_data | input | 32 | Command word |
| in_last | input | 1 | Word ends a batch (status reload) |
| in_ready | output | 1 | Framer can take a word |
| pkt_valid | output | 1 | Packet waiting on the output |
| pkt_ready | input | 1 | Consumer takes the packet |
| pkt_opcode | output | 8 | Opcode of the packet |
| pkt_count | output | 6 | Words in the packet (CNT_W) |
| pkt_words | output | 1024 | Packet words, slot k at bits 32k+31..32k (MAX_WORDS*32) |
| xfer_valid | output | 1 | Image transfer waiting |
| xfer_ready | input | 1 | Transfer engine takes it |
| xfer_read | output | 1 | 1 = read from image memory, 0 = write |
| xfer_pos | output | 32 | Position word of the transfer |
| xfer_size | output | 32 | Size word of the transfer |
| env_regs | output | 256 | Eight environment registers, register i at bits 32i+31..32i |
| status | output | 13 | Status bits from environment registers 1 and 6 |

## Verification
A wrong word counter or length decode does not stay hidden. The very next packet comes out with the wrong count. Its words are shifted, or the packet merges with its neighbour, so the error is visible at the first packet after the fault.

A wrong terminator-position rule shows up on the packet that contains the mistimed match. That packet ends early or late by one step.

Environment and status faults are visible on env_regs one edge after the write, and on status two edges after the batch end. A stuck pending flag shows as in_ready staying low, and the stream stalls at once.

// File: rtl/gpf_pkg.sv
// Package: shared constants, command classes and the opcode length rules
// for the command packet framer. Assumes 32-bit command words with the
// opcode in the top byte.
package gpf_pkg;
    localparam int WORD_W  = 32;
    localparam int OP_W    = 8;
    localparam int ENV_NUM = 8;
    localparam int STAT_W  = 13;

    localparam logic [WORD_W-1:0] TERM_MASK = 32'hF000_F000;
    localparam logic [WORD_W-1:0] TERM_VAL  = 32'h5000_5000;

    typedef enum logic [1:0] {
        CLS_FIXED = 2'd0,
        CLS_POLY1 = 2'd1,
        CLS_POLY2 = 2'd2,
        CLS_IMAGE = 2'd3
    } cmd_class_e;

    // Extra words after the first word, derived from the opcode bit fields.
    function automatic logic [3:0] extra_words(input logic [OP_W-1:0] op);
        logic [3:0] nv;
        logic [3:0] per_v;
        logic [3:0] res;
        res = 4'd0;
        if (op == 8'h02) begin
            res = 4'd2;
        end else if (op[7:5] == 3'b001) begin
            nv    = op[3] ? 4'd4 : 4'd3;
            per_v = op[2] ? 4'd2 : 4'd1;
            res   = 4'(nv * per_v) + (op[4] ? 4'(nv - 4'd1) : 4'd0);
        end else if (op[7:5] == 3'b010) begin
            res = op[4] ? 4'd3 : 4'd2;
        end else if (op[7:5] == 3'b011) begin
            res = 4'd1 + (op[2] ? 4'd1 : 4'd0) + ((op[4:3] == 2'b00) ? 4'd1 : 4'd0);
        end else if (op == 8'h80) begin
            res = 4'd3;
        end
        return res;
    endfunction

    // Framing class of an opcode.
    function automatic cmd_class_e classify(input logic [OP_W-1:0] op);
        cmd_class_e c;
        c = CLS_FIXED;
        if (op[7:3] == 5'b01001)                 c = CLS_POLY1;
        else if (op[7:3] == 5'b01011)            c = CLS_POLY2;
        else if (op >= 8'hA0 && op <= 8'hDF)     c = CLS_IMAGE;
        return c;
    endfunction
endpackage

// File: rtl/gpf_decode.sv
// Opcode decoder: maps an opcode to its framing class and extra-word count.
// Purely combinational; assumes the opcode is already selected by the caller.
module gpf_decode
    import gpf_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output cmd_class_e      cls,
    output logic [3:0]      extra
);
    // Decode class and length from the opcode bits.
    always_comb begin
        cls   = classify(opcode);
        extra = extra_words(opcode);
    end
endmodule

// File: rtl/gpf_term_detect.sv
// Line-strip terminator detector: flags a word that matches the end pattern
// at a position where the packet's class allows it to end the strip.
// Assumes idx is the index of the word within its packet.
module gpf_term_detect
    import gpf_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  idx,
    input  cmd_class_e        cls,
    output logic              hit
);
    logic pattern;
    logic pos_one;
    logic pos_two;

    // Pattern match and allowed-position tests for both step sizes.
    always_comb begin
        pattern = ((word & TERM_MASK) == TERM_VAL);
        pos_one = (idx >= CNT_W'(3));
        pos_two = (idx >= CNT_W'(4)) && !idx[0];
        unique case (cls)
            CLS_POLY1: hit = pattern && pos_one;
            CLS_POLY2: hit = pattern && pos_two;
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpf_env.sv
// Environment register file and status word. Settings words are stored
// whole; status is reloaded one edge after a batch end is seen, so that a
// write made by the batch's last word is already visible.
module gpf_env
    import gpf_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [2:0]                wr_idx,
    input  logic [WORD_W-1:0]         wr_data,
    input  logic                      batch_end,
    output logic [ENV_NUM*WORD_W-1:0] env_regs,
    output logic [STAT_W-1:0]         status
);
    logic batch_q;

    for (genvar g = 0; g < ENV_NUM; g++) begin : g_env
        logic [WORD_W-1:0] env_q;
        // Hold one environment register; reset value carries its own opcode.
        always_ff @(posedge clk) begin
            if (!rst_n)
                env_q <= WORD_W'(OP_W'(8'hE0 + g)) << 24;
            else if (wr_en && wr_idx == 3'(g))
                env_q <= wr_data;
        end
        assign env_regs[g*WORD_W +: WORD_W] = env_q;
    end

    // Delay the batch end by one edge, then reload the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            batch_q <= 1'b0;
            status  <= '0;
        end else begin
            batch_q <= batch_end;
            if (batch_q)
                status <= {env_regs[6*WORD_W +: 2], env_regs[1*WORD_W +: 11]};
        end
    end
endmodule

// File: rtl/gpf_framer.sv
// Command packet framer (top). Collects command words into packets whose
// length follows from the opcode, ends line strips on a terminator, diverts
// image-transfer commands to a transfer port and feeds settings words to the
// environment registers. Assumes MAX_WORDS >= 12 so the longest fixed packet
// fits. One packet or transfer is held at a time; input stalls meanwhile.
module gpf_framer
    import gpf_pkg::*;
#(
    parameter  int MAX_WORDS = 32,
    localparam int CNT_W     = $clog2(MAX_WORDS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_flush,
    input  logic                        in_valid,
    input  logic [WORD_W-1:0]           in_data,
    input  logic                        in_last,
    output logic                        in_ready,
    output logic                        pkt_valid,
    input  logic                        pkt_ready,
    output logic [OP_W-1:0]             pkt_opcode,
    output logic [CNT_W-1:0]            pkt_count,
    output logic [MAX_WORDS*WORD_W-1:0] pkt_words,
    output logic                        xfer_valid,
    input  logic                        xfer_ready,
    output logic                        xfer_read,
    output logic [WORD_W-1:0]           xfer_pos,
    output logic [WORD_W-1:0]           xfer_size,
    output logic [ENV_NUM*WORD_W-1:0]   env_regs,
    output logic [STAT_W-1:0]           status
);
    logic [CNT_W-1:0] cnt_q;
    logic [OP_W-1:0]  op_q;
    logic [OP_W-1:0]  out_op_q;
    logic [CNT_W-1:0] out_cnt_q;
    logic             pkt_valid_q;
    logic             xfer_valid_q;
    logic             xfer_read_q;

    logic             accept;
    logic [OP_W-1:0]  cur_op;
    cmd_class_e       cls;
    logic [3:0]       extra;
    logic             term_hit;
    logic             done;
    logic             env_wr;

    assign in_ready = !pkt_valid_q && !xfer_valid_q && !cmd_flush;
    assign accept   = in_valid && in_ready;
    assign cur_op   = (cnt_q == '0) ? in_data[WORD_W-1 -: OP_W] : op_q;
    assign env_wr   = accept && (cnt_q == '0) && (in_data[31:27] == 5'b11100);

    gpf_decode u_dec (
        .opcode (cur_op),
        .cls    (cls),
        .extra  (extra)
    );

    gpf_term_detect #(.CNT_W(CNT_W)) u_term (
        .word (in_data),
        .idx  (cnt_q),
        .cls  (cls),
        .hit  (term_hit)
    );

    gpf_env u_env (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (env_wr),
        .wr_idx    (in_data[26:24]),
        .wr_data   (in_data),
        .batch_end (accept && in_last),
        .env_regs  (env_regs),
        .status    (status)
    );

    // Decide whether the word now arriving closes its packet.
    always_comb begin
        unique case (cls)
            CLS_FIXED: done = (cnt_q == CNT_W'(extra));
            CLS_IMAGE: done = (cnt_q == CNT_W'(2));
            default:   done = term_hit || (cnt_q == CNT_W'(MAX_WORDS - 1));
        endcase
    end

    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_slot
        logic [WORD_W-1:0] slot_q;
        // Store the word whose index matches this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= '0;
            else if (accept && cnt_q == CNT_W'(g))
                slot_q <= in_data;
        end
        assign pkt_words[g*WORD_W +: WORD_W] = slot_q;
    end

    // Word counter, packet and transfer hand-off, flush handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            op_q         <= '0;
            out_op_q     <= '0;
            out_cnt_q    <= '0;
            pkt_valid_q  <= 1'b0;
            xfer_valid_q <= 1'b0;
            xfer_read_q  <= 1'b0;
        end else if (cmd_flush) begin
            cnt_q        <= '0;
            pkt_valid_q  <= 1'b0;
            xfer_valid_q <= 1'b0;
        end else begin
            if (pkt_valid_q && pkt_ready)
                pkt_valid_q <= 1'b0;
            if (xfer_valid_q && xfer_ready)
                xfer_valid_q <= 1'b0;
            if (accept) begin
                op_q <= cur_op;
                if (done) begin
                    cnt_q <= '0;
                    if (cls == CLS_IMAGE) begin
                        xfer_valid_q <= 1'b1;
                        xfer_read_q  <= (cur_op[7:5] == 3'b110);
                    end else begin
                        pkt_valid_q <= 1'b1;
                        out_op_q    <= cur_op;
                        out_cnt_q   <= cnt_q + CNT_W'(1);
                    end
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    assign pkt_valid  = pkt_valid_q;
    assign pkt_opcode = out_op_q;
    assign pkt_count  = out_cnt_q;
    assign xfer_valid = xfer_valid_q;
    assign xfer_read  = xfer_read_q;
    assign xfer_pos   = pkt_words[1*WORD_W +: WORD_W];
    assign xfer_size  = pkt_words[2*WORD_W +: WORD_W];
endmodule

// File: rtl/gpf_framer_chk.sv
// Checker for the command packet framer, bound to every instance of the top.
// Observes ports only.
module gpf_framer_chk
    import gpf_pkg::*;
#(
    parameter  int MAX_WORDS = 32,
    localparam int CNT_W     = $clog2(MAX_WORDS + 1)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cmd_flush,
    input logic                        in_ready,
    input logic                        pkt_valid,
    input logic                        pkt_ready,
    input logic [OP_W-1:0]             pkt_opcode,
    input logic [CNT_W-1:0]            pkt_count,
    input logic [MAX_WORDS*WORD_W-1:0] pkt_words,
    input logic                        xfer_valid
);
    logic [WORD_W-1:0] last_w;

    // Select the final word of the presented packet.
    always_comb begin
        last_w = '0;
        for (int i = 0; i < MAX_WORDS; i++)
            if (int'(pkt_count) == i + 1)
                last_w = pkt_words[i*WORD_W +: WORD_W];
    end

    assert_ready_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid || xfer_valid) |-> !in_ready);

    assert_pkt_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready && !cmd_flush) |=>
            (pkt_valid && $stable(pkt_opcode) && $stable(pkt_count)));

    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_flush |=> (!pkt_valid && !xfer_valid));

    assert_image_diverted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> !(pkt_opcode >= 8'hA0 && pkt_opcode <= 8'hDF));

    assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_count >= CNT_W'(1) && pkt_count <= CNT_W'(MAX_WORDS)));

    assert_poly_term_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_opcode[7:3] == 5'b01001 && pkt_count < CNT_W'(MAX_WORDS))
            |-> ((last_w & TERM_MASK) == TERM_VAL));
endmodule

bind gpf_framer gpf_framer_chk #(.MAX_WORDS(MAX_WORDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_flush  (cmd_flush),
    .in_ready   (in_ready),
    .pkt_valid  (pkt_valid),
    .pkt_ready  (pkt_ready),
    .pkt_opcode (pkt_opcode),
    .pkt_count  (pkt_count),
    .pkt_words  (pkt_words),
    .xfer_valid (xfer_valid)
);

// File: tb/gpf_framer_tb.sv
`timescale 1ns/1ps
module gpf_framer_tb;
    localparam int MAXW  = 32;
    localparam int CW    = $clog2(MAXW + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_flush = 1'b0;
    logic in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic in_last = 1'b0;
    logic in_ready;
    logic pkt_valid;
    logic pkt_ready = 1'b1;
    logic [7:0] pkt_opcode;
    logic [CW-1:0] pkt_count;
    logic [MAXW*32-1:0] pkt_words;
    logic xfer_valid;
    logic xfer_ready = 1'b1;
    logic xfer_read;
    logic [31:0] xfer_pos, xfer_size;
    logic [255:0] env_regs;
    logic [12:0] status;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit bp_en = 1'b0;
    bit finished = 1'b0;

    int          q_op[$];
    int          q_cnt[$];
    logic [31:0] q_w[$];
    bit          q_xr[$];
    logic [31:0] q_xp[$];
    logic [31:0] q_xs[$];
    logic [31:0] wb[64];

    always #2.5 clk = ~clk;

    gpf_framer #(.MAX_WORDS(MAXW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_flush(cmd_flush),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_opcode(pkt_opcode),
        .pkt_count(pkt_count), .pkt_words(pkt_words),
        .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_read(xfer_read),
        .xfer_pos(xfer_pos), .xfer_size(xfer_size),
        .env_regs(env_regs), .status(status)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: set backpressure for the next edge, then compare what will be taken.
    always @(negedge clk) begin
        cyc++;
        pkt_ready = bp_en ? (cyc % 3 != 0) : 1'b1;
        if (rst_n && (pkt_valid || xfer_valid))
            chk("R11 in_ready while pending", 64'(in_ready), 64'd0);
        if (rst_n && pkt_valid && pkt_ready) begin
            if (q_op.size() == 0) begin
                chk("R1 unexpected packet", 64'(pkt_opcode), 64'hFFFF);
            end else begin
                int eo, ec;
                eo = q_op.pop_front();
                ec = q_cnt.pop_front();
                chk("R1 opcode", 64'(pkt_opcode), 64'(eo));
                chk("R1 R2 R3 R4 count", 64'(pkt_count), 64'(ec));
                for (int k = 0; k < ec; k++) begin
                    logic [31:0] ew;
                    ew = q_w.pop_front();
                    if (k < MAXW) chk("R1 word", 64'(pkt_words[k*32 +: 32]), 64'(ew));
                end
            end
        end
        if (rst_n && xfer_valid && xfer_ready) begin
            if (q_xr.size() == 0) begin
                chk("R5 unexpected transfer", 64'(xfer_pos), 64'hFFFF);
            end else begin
                chk("R5 xfer_read", 64'(xfer_read), 64'(q_xr.pop_front()));
                chk("R5 xfer_pos", 64'(xfer_pos), 64'(q_xp.pop_front()));
                chk("R5 xfer_size", 64'(xfer_size), 64'(q_xs.pop_front()));
            end
        end
    end

    task automatic send_word(input logic [31:0] d, input logic l);
        bit ok;
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_last = l;
        forever begin
            ok = in_ready;
            @(negedge clk);
            if (ok) break;
        end
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    // Driver: push the expected item, then send wb[0..n-1].
    task automatic run_pkt(input int n, input bit img);
        if (img) begin
            q_xr.push_back(wb[0][31:29] == 3'b110);
            q_xp.push_back(wb[1]);
            q_xs.push_back(wb[2]);
        end else begin
            q_op.push_back(int'(wb[0][31:24]));
            q_cnt.push_back(n);
            for (int k = 0; k < n; k++) q_w.push_back(wb[k]);
        end
        for (int k = 0; k < n; k++) send_word(wb[k], k == n - 1);
    endtask

    task automatic fill(input logic [7:0] op, input int n, input int seed);
        wb[0] = {op, 24'(seed * 24'h010203)};
        for (int k = 1; k < n; k++) wb[k] = 32'h0101_0000 + 32'(seed * 64 + k);
    endtask

    task automatic fixed_pkt(input logic [7:0] op, input int extra, input int seed);
        fill(op, extra + 1, seed);
        run_pkt(extra + 1, 1'b0);
    endtask

    task automatic drain();
        for (int k = 0; k < 400; k++) begin
            if (q_op.size() == 0 && q_xr.size() == 0 && !pkt_valid && !xfer_valid) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset state
        chk("R7 in_ready", 64'(in_ready), 64'd1);
        chk("R7 pkt_valid", 64'(pkt_valid), 64'd0);
        chk("R7 xfer_valid", 64'(xfer_valid), 64'd0);
        chk("R7 status", 64'(status), 64'd0);
        for (int i = 0; i < 8; i++)
            chk("R7 env reset", 64'(env_regs[i*32 +: 32]), 64'(32'(8'hE0 + i) << 24));

        // R1: fixed-length opcodes
        fixed_pkt(8'h02, 2, 1);
        fixed_pkt(8'h20, 3, 2);
        fixed_pkt(8'h27, 6, 3);
        fixed_pkt(8'h29, 4, 4);
        fixed_pkt(8'h2E, 8, 5);
        fixed_pkt(8'h31, 5, 6);
        fixed_pkt(8'h36, 8, 7);
        fixed_pkt(8'h3B, 7, 8);
        fixed_pkt(8'h3C, 11, 9);
        fixed_pkt(8'h00, 0, 10);
        fixed_pkt(8'hF3, 0, 11);
        drain();

        // R11: same stream under output backpressure
        bp_en = 1'b1;
        fixed_pkt(8'h3F, 11, 12);
        fixed_pkt(8'h24, 6, 13);
        fixed_pkt(8'h02, 2, 14);
        drain();
        bp_en = 1'b0;

        // R6 R8: environment writes and status reload
        wb[0] = 32'hE100_05A5; run_pkt(1, 1'b0);
        chk("R6 env1 written", 64'(env_regs[32 +: 32]), 64'h E100_05A5);
        @(negedge clk);
        chk("R8 status after env1", 64'(status), 64'(13'h05A5));
        wb[0] = 32'hE600_0003; run_pkt(1, 1'b0);
        @(negedge clk);
        chk("R8 status after env6", 64'(status), 64'({2'b11, 11'h5A5}));
        wb[0] = 32'hE800_1234; run_pkt(1, 1'b0);
        chk("R6 0xE8 leaves env0", 64'(env_regs[0 +: 32]), 64'hE000_0000);
        chk("R6 0xE8 leaves env1", 64'(env_regs[32 +: 32]), 64'hE100_05A5);
        drain();

        // R2: one-step strip, early match at index 1 ignored, end at index 4
        wb[0] = 32'h4800_0000; wb[1] = 32'h5000_5000; wb[2] = 32'h0011_0022;
        wb[3] = 32'h0033_0044; wb[4] = 32'h5555_5555;
        run_pkt(5, 1'b0);
        // R2: end at the earliest allowed index 3
        wb[0] = 32'h4F00_0000; wb[1] = 32'h0001_0001; wb[2] = 32'h0002_0002;
        wb[3] = 32'h5ABC_5DEF;
        run_pkt(4, 1'b0);
        // R3: two-step strip, odd-index match at 5 ignored, end at index 8
        wb[0] = 32'h5800_0000;
        for (int k = 1; k < 8; k++) wb[k] = 32'h0100_0100 + 32'(k);
        wb[5] = 32'h5000_5000;
        wb[8] = 32'h5FFF_5FFF;
        run_pkt(9, 1'b0);
        // R3: end at index 4
        wb[0] = 32'h5C00_0000; wb[1] = 32'h1; wb[2] = 32'h2; wb[3] = 32'h5000_5000;
        wb[4] = 32'h5000_5000;
        run_pkt(5, 1'b0);
        // R4: no terminator, capped at MAX_WORDS
        wb[0] = 32'h4A00_0000;
        for (int k = 1; k < MAXW; k++) wb[k] = 32'h0202_0000 + 32'(k);
        run_pkt(MAXW, 1'b0);
        drain();

        // R5: image transfers
        wb[0] = 32'hA000_0000; wb[1] = 32'h0010_0020; wb[2] = 32'h0008_0004; run_pkt(3, 1'b1);
        wb[0] = 32'hC000_0000; wb[1] = 32'h0030_0040; wb[2] = 32'h0002_0002; run_pkt(3, 1'b1);
        wb[0] = 32'hBF00_0000; wb[1] = 32'h0001_0002; wb[2] = 32'h0003_0004; run_pkt(3, 1'b1);
        wb[0] = 32'hDF00_0000; wb[1] = 32'h0005_0006; wb[2] = 32'h0007_0008; run_pkt(3, 1'b1);
        fixed_pkt(8'h2C, 8, 20);
        drain();

        // R9: partial packet held
        fill(8'h20, 4, 21);
        q_op.push_back(8'h20); q_cnt.push_back(4);
        for (int k = 0; k < 4; k++) q_w.push_back(wb[k]);
        send_word(wb[0], 1'b0);
        send_word(wb[1], 1'b0);
        repeat (20) @(negedge clk);
        chk("R9 partial not emitted", 64'(pkt_valid), 64'd0);
        send_word(wb[2], 1'b0);
        send_word(wb[3], 1'b1);
        drain();
        chk("R9 packet completed", 64'(q_op.size()), 64'd0);

        // R10: flush drops a partial packet
        fill(8'h28, 5, 22);
        send_word(wb[0], 1'b0);
        send_word(wb[1], 1'b0);
        @(negedge clk); cmd_flush = 1'b1;
        @(negedge clk); cmd_flush = 1'b0;
        chk("R10 nothing after flush", 64'(pkt_valid), 64'd0);
        fixed_pkt(8'h20, 3, 23);
        drain();
        // R10: flush drops a pending packet
        bp_en = 1'b0;
        @(negedge clk); xfer_ready = 1'b0;
        wb[0] = 32'hA100_0000; wb[1] = 32'h1; wb[2] = 32'h2;
        for (int k = 0; k < 3; k++) send_word(wb[k], 1'b0);
        chk("R5 transfer waiting", 64'(xfer_valid), 64'd1);
        cmd_flush = 1'b1;
        @(negedge clk); cmd_flush = 1'b0;
        xfer_ready = 1'b1;
        chk("R10 pending transfer dropped", 64'(xfer_valid), 64'd0);
        fixed_pkt(8'h38, 7, 24);
        drain();

        chk("R1 all packets seen", 64'(q_op.size() + q_xr.size()), 64'd0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R11 actual=stalled expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule